// File: doc/BRIEF.md
# Transition-Signalled Dual-Rail Word Bridge

This block moves multi-bit words between a clocked domain and a set of transition-signalled dual-rail wires. Every bit of the word travels on a pair of wires, a "one" rail and a "zero" rail. A bit is sent by flipping exactly one wire of its pair: a flip on the one rail carries a 1, a flip on the zero rail carries a 0. The level of a wire carries no meaning. Only the change from the level it had after the previous word matters.

The transmit half accepts a word on a valid/ready stream and flips the chosen rail of every bit in one cycle. It then holds `s_ready` low until the far receiver signals, by flipping its acknowledge wire, that it has taken the word. A word offered while `s_ready` is low is not taken and leaves the rails as they are. Back-pressure is therefore set entirely by the round trip of the acknowledge.

The receive half passes its incoming rails through two-flop synchronisers. It keeps a reference copy of every rail level and treats a bit as arrived once either rail of that bit differs from its reference. When all bits have arrived, it either presents the decoded word with a one-cycle `m_valid` strobe, or raises a one-cycle `m_err` if some bit flipped both rails. In both cases it reloads the references from the current levels and flips its own acknowledge wire. The receive output has no ready: a consumer must take each strobe in the cycle it appears.

Top module: `toggle_rail_bridge`

## Requirements
- R1: When a word is accepted (`s_valid` and `s_ready` high at a rising edge), after that edge `tx_one[i]` has flipped for every bit with `s_data[i]`=1 and `tx_zero[i]` has flipped for every bit with `s_data[i]`=0. Exactly one rail of each bit flips.
- R2: In any cycle without an accepted word, both transmit rail vectors keep their levels.
- R3: `s_ready` is low in the cycle after an acceptance and stays low until a flip of `ack_in` has passed the two-flop synchroniser. It returns high on the third rising edge after the flip. A word offered while `s_ready` is low is ignored.
- R4: A receive bit counts as arrived when either of its rails differs from its reference level. A word completes only when all bits have arrived. A partial set of flips produces no `m_valid`, no `m_err` and no flip of `rx_ack`.
- R5: For a complete word with one rail flipped per bit, `m_data[i]` is 1 when the one rail flipped and 0 when the zero rail flipped. `m_valid` is high for exactly one cycle.
- R6: On completion the references take the current rail levels. Rails that then stay still produce no further word, and the next word is detected from new flips only.
- R7: If any bit of a complete word flipped both of its rails, `m_err` pulses for one cycle, `m_valid` stays low, and the word is discarded.
- R8: `rx_ack` flips exactly once for every completed word, whether it was good or in error, in the same cycle as the `m_valid` or `m_err` pulse.
- R9: While `rst` is high, both transmit rail vectors are cleared to zero, `s_ready` goes high, `rx_ack` goes to 0, and the receive references load the present synchronised rail levels. Rail levels that are non-zero and steady across reset therefore produce no word.
- R10: With the default two synchroniser stages, a complete word applied to the receive rails appears on `m_valid` at the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Transmit word offered |
| s_ready | output | 1 | Transmit side can take a word |
| s_data | input | W | Word to transmit |
| tx_one | output | W | Transmit one rails (flip means 1) |
| tx_zero | output | W | Transmit zero rails (flip means 0) |
| ack_in | input | 1 | Far receiver's acknowledge, a flip per word taken |
| rx_one | input | W | Receive one rails, asynchronous |
| rx_zero | input | W | Receive zero rails, asynchronous |
| rx_ack | output | 1 | Acknowledge, flips once per completed received word |
| m_valid | output | 1 | One-cycle strobe with a decoded word |
| m_data | output | W | Decoded word |
| m_err | output | 1 | One-cycle strobe for a word with a bit that flipped both rails |

## Verification
The hardest situations to reach are a word whose bits arrive in different cycles, and a word in which one bit flips both rails while all the other bits are clean. A word that is coherent at the source never produces either of these. The bench therefore drives the receive rails itself and can split a word into two groups of flips several cycles apart. It also holds back the last bit for a long stretch to confirm that nothing is emitted. Finally, it flips both rails of a chosen bit to force the error path, and follows that with a clean word to show that the references were resynchronised.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int unsigned TRB_WIDTH  = 8;
  localparam int unsigned TRB_STAGES = 2;

  // Rails that moved relative to their reference level
  function automatic logic [63:0] trb_moved(input logic [63:0] now_lvl,
                                            input logic [63:0] ref_lvl);
    return now_lvl ^ ref_lvl;
  endfunction
endpackage

// File: rtl/trb_sync.sv
module trb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) chain[k] <= chain[k-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/trb_tx.sv
module trb_tx #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic [W-1:0] tx_one,
  output logic [W-1:0] tx_zero,
  input  logic         ack_in
);
  logic ack_s;
  logic ack_ref;
  logic busy;

  trb_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk (clk),
    .d   (ack_in),
    .q   (ack_s)
  );

  assign s_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_one  <= '0;
      tx_zero <= '0;
      busy    <= 1'b0;
      ack_ref <= ack_s;
    end else if (s_valid && !busy) begin
      tx_one  <= tx_one ^ s_data;
      tx_zero <= tx_zero ^ ~s_data;
      busy    <= 1'b1;
    end else if (busy && (ack_s != ack_ref)) begin
      busy    <= 1'b0;
      ack_ref <= ack_s;
    end
  end

  // R1: one rail per bit flips, selected by the accepted data
  a_r1_rail_encode: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=>
      ((tx_one ^ $past(tx_one)) == $past(s_data)) &&
      (((tx_one ^ $past(tx_one)) ^ (tx_zero ^ $past(tx_zero))) == {W{1'b1}}));

  // R2: rails hold without an accepted word
  a_r2_rails_hold: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> ($stable(tx_one) && $stable(tx_zero)));

  // R3: acceptance closes the stream until acknowledged
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);
endmodule

// File: rtl/trb_rx.sv
module trb_rx #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rx_one,
  input  logic [W-1:0] rx_zero,
  output logic         rx_ack,
  output logic         m_valid,
  output logic [W-1:0] m_data,
  output logic         m_err
);
  import trb_pkg::*;

  logic [W-1:0] one_s, zero_s;
  logic [W-1:0] one_ref, zero_ref;
  logic [W-1:0] one_mv, zero_mv, arrived;
  logic         complete, clash;

  trb_sync #(.W(W), .STAGES(STAGES)) u_one_sync (
    .clk (clk), .d (rx_one), .q (one_s)
  );
  trb_sync #(.W(W), .STAGES(STAGES)) u_zero_sync (
    .clk (clk), .d (rx_zero), .q (zero_s)
  );

  always_comb begin
    one_mv   = W'(trb_moved(64'(one_s), 64'(one_ref)));
    zero_mv  = W'(trb_moved(64'(zero_s), 64'(zero_ref)));
    arrived  = one_mv | zero_mv;
    complete = &arrived;
    clash    = |(one_mv & zero_mv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      one_ref  <= one_s;
      zero_ref <= zero_s;
      rx_ack   <= 1'b0;
      m_valid  <= 1'b0;
      m_err    <= 1'b0;
      m_data   <= '0;
    end else begin
      m_valid <= complete && !clash;
      m_err   <= complete && clash;
      if (complete) begin
        one_ref  <= one_s;
        zero_ref <= zero_s;
        rx_ack   <= ~rx_ack;
        m_data   <= one_mv;
      end
    end
  end

  // R5 / R7: a completed word is either good or in error, never both
  a_r7_excl_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({m_valid, m_err}));

  // R8: acknowledge flips with every strobe
  a_r8_ack_flips: assert property (@(posedge clk) disable iff (rst)
    (m_valid || m_err) |-> (rx_ack != $past(rx_ack)));

  // R4 / R8: acknowledge is still between words
  a_r4_ack_quiet: assert property (@(posedge clk) disable iff (rst)
    !(m_valid || m_err) |-> $stable(rx_ack));
endmodule

// File: rtl/toggle_rail_bridge.sv
module toggle_rail_bridge #(
  parameter int unsigned W      = trb_pkg::TRB_WIDTH,
  parameter int unsigned STAGES = trb_pkg::TRB_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic [W-1:0] tx_one,
  output logic [W-1:0] tx_zero,
  input  logic         ack_in,
  input  logic [W-1:0] rx_one,
  input  logic [W-1:0] rx_zero,
  output logic         rx_ack,
  output logic         m_valid,
  output logic [W-1:0] m_data,
  output logic         m_err
);
  trb_tx #(.W(W), .STAGES(STAGES)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .tx_one  (tx_one),
    .tx_zero (tx_zero),
    .ack_in  (ack_in)
  );

  trb_rx #(.W(W), .STAGES(STAGES)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .rx_one  (rx_one),
    .rx_zero (rx_zero),
    .rx_ack  (rx_ack),
    .m_valid (m_valid),
    .m_data  (m_data),
    .m_err   (m_err)
  );
endmodule

// File: tb/toggle_rail_bridge_tb_top.sv
module toggle_rail_bridge_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [W-1:0] s_data = '0;
  logic [W-1:0] tx_one, tx_zero;
  logic         ack_in = 1'b0;
  logic [W-1:0] rx_one = '0, rx_zero = '0;
  logic         rx_ack, m_valid, m_err;
  logic [W-1:0] m_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  toggle_rail_bridge #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .tx_one(tx_one), .tx_zero(tx_zero), .ack_in(ack_in),
    .rx_one(rx_one), .rx_zero(rx_zero), .rx_ack(rx_ack),
    .m_valid(m_valid), .m_data(m_data), .m_err(m_err)
  );

  function automatic logic [W-1:0] exp_one(input logic [W-1:0] old, input logic [W-1:0] d);
    return old ^ d;
  endfunction
  function automatic logic [W-1:0] exp_zero(input logic [W-1:0] old, input logic [W-1:0] d);
    return old ^ ~d;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Waits for a receive strobe; returns 1 for valid, 2 for error, 0 for none
  task automatic wait_rx(input int limit, output int kind, output logic [W-1:0] data);
    kind = 0; data = '0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (m_valid || m_err) begin
        kind = m_valid ? 1 : 2;
        data = m_data;
        break;
      end
    end
  endtask

  task automatic quiet_rx(input int n, input string tag);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (m_valid || m_err) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic tx_word(input logic [W-1:0] d, input int hold);
    logic [W-1:0] o1, o0;
    o1 = tx_one; o0 = tx_zero;
    chk(s_ready == 1'b1, "R3 ready before send", s_ready, 1);
    s_valid = 1'b1; s_data = d;
    @(negedge clk);
    chk(tx_one == exp_one(o1, d), "R1 one rails", tx_one, exp_one(o1, d));
    chk(tx_zero == exp_zero(o0, d), "R1 zero rails", tx_zero, exp_zero(o0, d));
    chk(s_ready == 1'b0, "R3 ready low after accept", s_ready, 0);
    o1 = tx_one; o0 = tx_zero;
    for (int k = 0; k < hold; k++) begin
      s_data = W'($urandom);
      @(negedge clk);
    end
    chk(tx_one == o1 && tx_zero == o0, "R2/R3 rails held while busy", {tx_one, tx_zero}, {o1, o0});
    s_valid = 1'b0;
    ack_in = ~ack_in;
    cyc(2);
    chk(s_ready == 1'b0, "R3 ready low during ack sync", s_ready, 0);
    cyc(1);
    chk(s_ready == 1'b1, "R3 ready back after ack", s_ready, 1);
  endtask

  initial begin
    int kind;
    logic [W-1:0] got, d, part, lvl1, lvl0;
    void'($urandom(32'h5EED_2B1D));

    // Reset with steady non-zero receive rails
    rx_one = 8'hA5; rx_zero = 8'h3C;
    cyc(5);
    rst = 1'b0;
    chk(tx_one == '0 && tx_zero == '0, "R9 tx rails zero", {tx_one, tx_zero}, 0);
    chk(s_ready == 1'b1, "R9 ready after reset", s_ready, 1);
    chk(rx_ack == 1'b0, "R9 rx_ack zero", rx_ack, 0);
    quiet_rx(8, "R9 steady rails give no word");

    // Exact latency of a received word
    d = 8'h96;
    rx_one = rx_one ^ d; rx_zero = rx_zero ^ ~d;
    cyc(2);
    chk(m_valid == 1'b0, "R10 no strobe before third edge", m_valid, 0);
    cyc(1);
    chk(m_valid == 1'b1, "R10 strobe at third edge", m_valid, 1);
    chk(m_data == d, "R5 decoded data", m_data, d);
    chk(rx_ack == 1'b1, "R8 ack flipped", rx_ack, 1);
    cyc(1);
    chk(m_valid == 1'b0, "R5 strobe one cycle", m_valid, 0);
    quiet_rx(8, "R6 no repeat on still rails");

    // Partial word: all but the top bit
    d = 8'h4B;
    part = d & 8'h7F;
    rx_one = rx_one ^ part; rx_zero = rx_zero ^ (~d & 8'h7F);
    lvl1 = rx_ack;
    quiet_rx(12, "R4 partial word silent");
    chk(rx_ack == lvl1[0], "R4 no ack on partial", rx_ack, lvl1[0]);
    rx_one = rx_one ^ (d & 8'h80); rx_zero = rx_zero ^ (~d & 8'h80);
    wait_rx(8, kind, got);
    chk(kind == 1 && got == d, "R4/R5 late bit completes word", {kind[7:0], got}, {8'd1, d});

    // Both rails of bit 3 flip: error, then clean word
    lvl1 = {7'd0, rx_ack};
    d = 8'h21;
    rx_one = rx_one ^ (d | 8'h08); rx_zero = rx_zero ^ (~d | 8'h08);
    wait_rx(8, kind, got);
    chk(kind == 2, "R7 double flip gives error", kind, 2);
    chk(rx_ack != lvl1[0], "R8 ack flips on error", rx_ack, ~lvl1[0]);
    cyc(1);
    chk(m_err == 1'b0 && m_valid == 1'b0, "R7 error one cycle, no valid", {m_err, m_valid}, 0);
    d = 8'hD2;
    rx_one = rx_one ^ d; rx_zero = rx_zero ^ ~d;
    wait_rx(8, kind, got);
    chk(kind == 1 && got == d, "R6 clean word after error", {kind[7:0], got}, {8'd1, d});

    // Random receive words, some skewed
    for (int n = 0; n < 40; n++) begin
      int gap;
      d = W'($urandom);
      part = W'($urandom) & ~8'h01;
      gap = int'($urandom % 4);
      lvl0 = {7'd0, rx_ack};
      rx_one = rx_one ^ (d & part); rx_zero = rx_zero ^ (~d & part);
      if (gap > 0) begin
        quiet_rx(gap, "R4 skewed partial silent");
      end
      rx_one = rx_one ^ (d & ~part); rx_zero = rx_zero ^ (~d & ~part);
      wait_rx(8, kind, got);
      chk(kind == 1 && got == d, "R5 random word", {kind[7:0], got}, {8'd1, d});
      chk(rx_ack != lvl0[0], "R8 ack per word", rx_ack, ~lvl0[0]);
    end

    // Transmit: directed corners then random
    tx_word(8'h00, 0);
    tx_word(8'hFF, 3);
    for (int n = 0; n < 40; n++) begin
      tx_word(W'($urandom), int'($urandom % 4));
    end
    lvl1 = tx_one; lvl0 = tx_zero;
    s_valid = 1'b0;
    cyc(4);
    chk(tx_one == lvl1 && tx_zero == lvl0, "R2 idle rails hold", {tx_one, tx_zero}, {lvl1, lvl0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule